// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

The block is one general-purpose I/O port of `PINS` pins behind a small memory-mapped register bus. Software drives the pads through an output data register and a per-pin output-enable register, and reads pad values back through an input register. The input register is fed by a two-flop synchronizer. The same synchronized values feed per-pin interrupt detection. That detection is configured by a source-select mask, an enable mask, a level/edge mode register and a polarity register, and it records events in a sticky status register. One registered interrupt line summarizes the enabled pending pins of the whole port.

Each register kind occupies a 0x100-byte slot. Within a slot, word offset 0x0 replaces the register, 0x4 sets the bits written as one and 0x8 clears them. This lets software change single pins without a read-modify-write. The status register is special: only its clear alias changes it. A detection event wins over a clear of the same bit in the same cycle, so no event is lost.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset all registers read zero, and `pad_out`, `pad_oe` and `irq` are zero.
- R2: Register kinds are selected by address bits [10:8]: 0 output data, 1 input, 2 output enable, 3 source select, 4 enable, 5 mode, 6 polarity, 7 status. Address bits [3:2] select the write action: 0 replaces, 1 ORs in the written ones, 2 clears the written ones, and 3 leaves the register unchanged. A read at any of these offsets returns the register value on `bus_rdata` one clock after `bus_rd`.
- R3: `pad_out` equals the output data register and `pad_oe` equals the output enable register, one bit per pin.
- R4: The input register returns `pad_in` through a two-flop synchronizer. A pad change made in the cycle before edge k1 is returned only by a read sampled at edge k3 or later; reads sampled at k1 or k2 return the old value. Writes to the input register are ignored.
- R5: The per-pin (mode, polarity) pair selects the detection: 00 falling edge, 01 rising edge when polarity is 1, 10 low level, 11 high level. Mode 1 means level and polarity 1 means high or rising. An edge sets the status bit once per transition of the synchronized pad.
- R6: In level mode the status bit is set again on every cycle in which the selected level is present, so a clear takes effect only after the level has gone.
- R7: A pin whose source-select bit is 0 never sets its status bit.
- R8: Status bits are sticky. A plain write or a set-alias write to the status register leaves it unchanged, and a clear-alias write of all ones clears every pending pin.
- R9: When a detection event and a clear of the same status bit fall in one cycle, the bit stays set.
- R10: `irq` is a register that goes to 1 one clock after any bit of (status AND enable) is 1. Pending pins whose enable bit is 0 do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data follows one clock later |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Registered read data |
| pad_in | input | PINS | Asynchronous pad input values |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad output enables |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench aims at the cycle in which the synchronizer latency ends. A design with one stage too few or too many would return the new pad value one read early or late. It holds a high or low level while software clears the status bit. A design that gave the clear priority, or that detected levels as edges, would drop or keep the bit wrongly there. It also holds a pad stable high after a rising-edge event has been cleared, which catches a design that treats a level as an edge and re-sets the bit. Plain and set-alias writes to status, writes to the input register and the unused fourth alias must all leave readback unchanged. Disabled pins must show pending status without raising `irq`, which would catch a detector or OR-tree that ignores source select or enable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    K_DOUT = 3'd0, K_DIN = 3'd1, K_OE = 3'd2, K_SRC = 3'd3,
    K_EN = 3'd4, K_MODE = 3'd5, K_POL = 3'd6, K_STAT = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    A_WRITE = 2'd0, A_SET = 2'd1, A_CLR = 2'd2, A_NONE = 2'd3
  } alias_e;

  localparam int KIND_LSB  = 8;
  localparam int ALIAS_LSB = 2;
  localparam int NUM_KINDS = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int PINS   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] async_i,
  output logic [PINS-1:0] sync_o
);
  logic [PINS-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= async_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] src_i,
  input  logic [PINS-1:0] mode_i,
  input  logic [PINS-1:0] pol_i,
  output logic [PINS-1:0] evt_o
);
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else prev_q <= pin_i;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic lvl_hit, edge_hit;
    always_comb begin
      lvl_hit  = pol_i[p] ? pin_i[p] : ~pin_i[p];
      edge_hit = pol_i[p] ? (pin_i[p] & ~prev_q[p]) : (~pin_i[p] & prev_q[p]);
      evt_o[p] = src_i[p] & (mode_i[p] ? lvl_hit : edge_hit);
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  kind_e           kind_i,
  input  alias_e          alias_i,
  input  logic [PINS-1:0] wdata_i,
  input  logic [PINS-1:0] evt_i,
  output logic [PINS-1:0] regs_o [NUM_KINDS]
);
  function automatic logic [PINS-1:0] apply(input logic [PINS-1:0] old,
                                            input alias_e a,
                                            input logic [PINS-1:0] d);
    case (a)
      A_WRITE: apply = d;
      A_SET:   apply = old | d;
      A_CLR:   apply = old & ~d;
      default: apply = old;
    endcase
  endfunction

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_reg
    if (k == int'(K_DIN)) begin : g_none
      assign regs_o[k] = '0;
    end else if (k == int'(K_STAT)) begin : g_stat
      logic [PINS-1:0] st_q, clr;
      assign clr = (wr_i && kind_i == K_STAT && alias_i == A_CLR) ? wdata_i : '0;
      always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else st_q <= (st_q & ~clr) | evt_i;
      end
      assign regs_o[k] = st_q;

      // R8: a status bit only drops after a clear-alias write of that bit
      assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ((($past(st_q) & ~st_q) & ~$past(clr)) == '0));
      // R9: every detection event leaves its bit set, whatever the clear
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (($past(evt_i) & ~st_q) == '0));
    end else begin : g_cfg
      logic [PINS-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr_i && kind_i == kind_e'(3'(k))) q <= apply(q, alias_i, wdata_i);
      end
      assign regs_o[k] = q;
    end
  end

  // R7: newly pending bits must belong to pins selected as sources
  assert_src_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (((regs_o[K_STAT] & ~$past(regs_o[K_STAT])) & ~$past(regs_o[K_SRC])) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  kind_e           kind;
  alias_e          alias_sel;
  logic [PINS-1:0] pin_sync, evt;
  logic [PINS-1:0] regs [NUM_KINDS];
  logic            unused_addr;

  assign kind        = kind_e'(bus_addr[KIND_LSB +: 3]);
  assign alias_sel   = alias_e'(bus_addr[ALIAS_LSB +: 2]);
  assign unused_addr = ^bus_addr;

  gpio_sync #(.PINS(PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(pad_in), .sync_o(pin_sync));

  gpio_detect #(.PINS(PINS)) u_detect (
    .clk(clk), .rst(rst), .pin_i(pin_sync),
    .src_i(regs[K_SRC]), .mode_i(regs[K_MODE]), .pol_i(regs[K_POL]),
    .evt_o(evt));

  gpio_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .kind_i(kind), .alias_i(alias_sel),
    .wdata_i(bus_wdata), .evt_i(evt), .regs_o(regs));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= (kind == K_DIN) ? pin_sync : regs[kind];
      irq <= |(regs[K_STAT] & regs[K_EN]);
    end
  end

  assign pad_out = regs[K_DOUT];
  assign pad_oe  = regs[K_OE];

  // R10: the interrupt follows enabled pending status by one clock
  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq == $past(|(regs[K_STAT] & regs[K_EN]))));
  // R3: pads follow the output registers, which change only on bus writes
  assert_pad_stable_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_wr) |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;
  logic [31:0] mreg [8];

  always #2 clk = ~clk;

  gpio_port #(.PINS(32), .ADDR_W(12)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  function automatic logic [11:0] ad(input int k, input int s);
    return 12'((k << 8) | (s << 2));
  endfunction

  function automatic logic [31:0] model(input logic [31:0] old, input int s,
                                        input logic [31:0] d);
    case (s)
      0: return d;
      1: return old | d;
      2: return old & ~d;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] r, b, a;
    int p;
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 8; k++) mreg[k] = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      rd(ad(k, 0), r);
      chk($sformatf("R1 reset reg %0d", k), r, 32'h0);
    end
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'h0, irq}, 0);

    // R2/R3 random alias traffic on configuration registers
    for (int i = 0; i < 200; i++) begin
      int k, s, rs;
      logic [31:0] d;
      k  = $urandom_range(5, 0);
      k  = (k == 0) ? 0 : k + 1;
      s  = $urandom_range(3, 0);
      rs = $urandom_range(2, 0);
      d  = $urandom;
      wr(ad(k, s), d);
      mreg[k] = model(mreg[k], s, d);
      rd(ad(k, rs), r);
      chk($sformatf("R2 reg %0d alias %0d", k, s), r, mreg[k]);
      chk("R3 pad_out", pad_out, mreg[0]);
      chk("R3 pad_oe", pad_oe, mreg[2]);
    end

    // quiesce interrupt configuration
    wr(ad(3, 0), 0); wr(ad(4, 0), 0); wr(ad(5, 0), 0); wr(ad(6, 0), 0);
    wr(ad(7, 2), 32'hffff_ffff);
    idle(2);
    rd(ad(7, 0), r);
    chk("R8 clear all ones", r, 0);
    idle(1);
    chk("R10 irq idle", {31'h0, irq}, 0);

    // R4 input latency and write immunity
    b = pad_in;
    a = $urandom | 32'h1;
    @(negedge clk);
    pad_in = a;
    rd_now(ad(1, 0), r);
    chk("R4 old after 1 edge", r, b);
    rd_now(ad(1, 0), r);
    chk("R4 old after 2 edges", r, b);
    rd_now(ad(1, 0), r);
    chk("R4 new after 3 edges", r, a);
    wr(ad(1, 0), ~a); wr(ad(1, 1), 32'hffff_ffff);
    rd(ad(1, 2), r);
    chk("R4 input ignores writes", r, a);
    wr(ad(0, 3), 32'hffff_ffff);
    rd(ad(0, 0), r);
    chk("R2 fourth alias ignored", r, mreg[0]);
    @(negedge clk); pad_in = '0; idle(4);

    // R5 rising edge on a random pin
    p = $urandom_range(31, 0);
    wr(ad(6, 0), 32'h1 << p);
    wr(ad(3, 0), 32'h1 << p);
    wr(ad(4, 0), 32'h1 << p);
    @(negedge clk);
    pad_in[p] = 1'b1;
    idle(3);
    chk("R10 irq not before status+1", {31'h0, irq}, 0);
    idle(1);
    chk("R10 irq raised", {31'h0, irq}, 1);
    rd(ad(7, 0), r);
    chk("R5 rising sets status", r, 32'h1 << p);
    wr(ad(7, 2), 32'h1 << p);
    idle(3);
    rd(ad(7, 0), r);
    chk("R5 edge sets once only", r, 0);
    chk("R10 irq dropped", {31'h0, irq}, 0);

    // R5 falling edge
    wr(ad(6, 2), 32'h1 << p);
    idle(3);
    rd(ad(7, 0), r);
    chk("R5 no event on polarity change", r, 0);
    @(negedge clk); pad_in[p] = 1'b0; idle(4);
    rd(ad(7, 0), r);
    chk("R5 falling sets status", r, 32'h1 << p);
    wr(ad(7, 2), 32'h1 << p);

    // R6/R9 high level
    wr(ad(5, 1), 32'h1 << p);
    wr(ad(6, 1), 32'h1 << p);
    wr(ad(7, 2), 32'hffff_ffff);
    idle(2);
    rd(ad(7, 0), r);
    chk("R6 no level while low", r, 0);
    @(negedge clk); pad_in[p] = 1'b1; idle(4);
    wr(ad(7, 2), 32'hffff_ffff);
    rd(ad(7, 0), r);
    chk("R9 clear during high level keeps bit", r, 32'h1 << p);
    @(negedge clk); pad_in[p] = 1'b0; idle(4);
    rd(ad(7, 0), r);
    chk("R6 sticky after level gone", r, 32'h1 << p);
    wr(ad(7, 2), 32'h1 << p);
    rd(ad(7, 0), r);
    chk("R6 clear after level gone", r, 0);

    // R5 low level
    wr(ad(6, 2), 32'h1 << p);
    idle(3);
    rd(ad(7, 0), r);
    chk("R5 low level sets status", r, 32'h1 << p);
    @(negedge clk); pad_in[p] = 1'b1; idle(4);
    wr(ad(7, 2), 32'h1 << p);
    rd(ad(7, 0), r);
    chk("R5 low level cleared when high", r, 0);

    // R7 source select gating
    wr(ad(3, 0), 0);
    wr(ad(5, 0), 0);
    wr(ad(6, 0), 32'hffff_ffff);
    @(negedge clk); pad_in = '0; idle(4);
    @(negedge clk); pad_in = 32'hffff_ffff; idle(4);
    rd(ad(7, 0), r);
    chk("R7 unselected pins stay clear", r, 0);
    chk("R7 irq stays low", {31'h0, irq}, 0);

    // R10 enable gating
    wr(ad(3, 0), 32'h1 << p);
    wr(ad(4, 0), 0);
    @(negedge clk); pad_in = '0; idle(4);
    @(negedge clk); pad_in[p] = 1'b1; idle(4);
    rd(ad(7, 0), r);
    chk("R10 disabled pin pending", r, 32'h1 << p);
    chk("R10 disabled pin no irq", {31'h0, irq}, 0);
    wr(ad(4, 1), 32'h1 << p);
    idle(1);
    chk("R10 irq after enable", {31'h0, irq}, 1);

    // R8 sticky against plain and set writes
    wr(ad(7, 0), 32'h0);
    rd(ad(7, 0), r);
    chk("R8 plain write ignored", r, 32'h1 << p);
    wr(ad(7, 1), 32'hffff_ffff);
    rd(ad(7, 1), r);
    chk("R8 set alias ignored", r, 32'h1 << p);
    wr(ad(7, 2), 32'hffff_ffff);
    idle(1);
    rd(ad(7, 0), r);
    chk("R8 clear all pending", r, 0);
    chk("R10 irq cleared", {31'h0, irq}, 0);

    done = 1;
    summary();
  end
endmodule